// File: doc/BRIEF.md
# Interrupt Source Controller

This block is the source layer of a two-level interrupt controller. It serves a fixed set of local sources, and each source is either message-style (edge-triggered) or level-sensitive, fixed at build time. For each source it keeps a destination server, an 8-bit priority, an 8-bit saved priority and a few status bits. When a source needs service, the block presents an offer to the presentation layer. An offer carries the server, the global interrupt number and the priority. A priority of 0xFF masks the source. Global numbers are the local index plus a base offset.

A single request channel carries two kinds of traffic. The first is feedback from the presentation layer: reject, end-of-interrupt and resend. The second is configuration commands: set entry, get entry, interrupt off and interrupt on. Each command is answered one cycle later with a response that has an error flag. The block remembers rejected and masked events and delivers them again later. A resend walks the sources one per clock. During that walk a busy flag is high, incoming requests are ignored and new raw edges are held.

At most one offer leaves the block per cycle. A resend walk has first claim on that slot. An accepted request comes next. Pending raw events come last, and among them the lowest local index wins.

Top module: `ics_source_ctl`

## Requirements
- R1: Synchronous reset clears every status bit and sets priority and saved priority of every source to 0xFF. After reset no offer, response or busy is present. Each source keeps its build-time type across reset.
- R2: A rising edge on a message source whose priority is not 0xFF produces exactly one offer in the second clock edge after the rise. The offer carries the stored server, the global number BASE+index and the stored priority.
- R3: A message source that rises while its priority is 0xFF produces no offer and is marked pending. A later set (opcode 3) or on (opcode 6) command that leaves a priority other than 0xFF offers it in the same cycle as the command response.
- R4: A level source is offered on a rising input only when it is unmasked and not already sent. The offer marks it sent. An end-of-interrupt (opcode 1) clears sent for a level source and has no effect on a message source.
- R5: A reject (opcode 0) marks the source rejected and clears its sent bit. On the next resend, a rejected message source is offered once and its rejected bit is cleared. A level source that is still asserted and not sent is offered again.
- R6: A resend (opcode 2) raises busy from the next cycle for exactly NUM_SRC cycles. The walk visits index i in the i-th busy cycle and issues that source's offer, if any, in that cycle. Requests presented while busy are dropped. Raw edges that arrive while busy are held and serviced after busy falls.
- R7: Set (opcode 3) writes server, priority and saved priority. Get (opcode 4) returns server and priority. A number outside [BASE, BASE+NUM_SRC) is rejected with an error response and no state change. So is a set with server >= NUM_SRV or priority > 0xFF.
- R8: Off (opcode 5) stores the current priority as saved priority and sets priority to 0xFF. On (opcode 6) copies the saved priority back into the priority.
- R9: When several raw events are pending, they are serviced one per cycle in ascending index order. A cycle with an accepted request services no raw event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_SRC | Raw interrupt inputs, one per source |
| req_vld_i | input | 1 | Request valid |
| req_op_i | input | 3 | Request opcode (0 reject, 1 EOI, 2 resend, 3 set, 4 get, 5 off, 6 on) |
| req_num_i | input | NUM_W | Global interrupt number of the request |
| req_srv_i | input | SRVIN_W | Server argument for set |
| req_pri_i | input | 9 | Priority argument for set (values above 0xFF are errors) |
| busy_o | output | 1 | Resend walk in progress |
| ofr_vld_o | output | 1 | Offer valid |
| ofr_srv_o | output | SRV_W | Offer destination server |
| ofr_num_o | output | NUM_W | Offer global interrupt number |
| ofr_pri_o | output | 8 | Offer priority |
| rsp_vld_o | output | 1 | Command response valid |
| rsp_err_o | output | 1 | Parameter error |
| rsp_srv_o | output | SRV_W | Server returned by get |
| rsp_pri_o | output | 8 | Priority returned by get |

## Verification
The bench builds the block with eight sources at base 16 and four servers. Local indices 0 to 3 are message sources and 4 to 7 are level sources. With this configuration every source can be swept individually and both types are covered side by side. Numbers just below and just above the window (15 and 24) can be driven. The server limit of four can be exceeded through the 8-bit server field. The full eight-cycle resend walk can be observed cycle by cycle, including a held raw edge and a dropped request during the walk.

// File: rtl/ics_pkg.sv
package ics_pkg;
  typedef enum logic [2:0] {
    OP_REJECT = 3'd0,
    OP_EOI    = 3'd1,
    OP_RESEND = 3'd2,
    OP_SET    = 3'd3,
    OP_GET    = 3'd4,
    OP_OFF    = 3'd5,
    OP_ON     = 3'd6
  } ics_op_e;

  localparam logic [7:0] PRI_MASKED = 8'hFF;
endpackage

// File: rtl/ics_edge_capture.sv
module ics_edge_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] ev_o
);
  logic [N-1:0] lvl_q, ev_q;

  // Rising edges are latched until the owner clears them.
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      ev_q  <= '0;
    end else begin
      lvl_q <= irq_i;
      ev_q  <= (ev_q & ~clr_i) | (irq_i & ~lvl_q);
    end
  end

  assign lvl_o = lvl_q;
  assign ev_o  = ev_q;
endmodule

// File: rtl/ics_pick_low.sv
module ics_pick_low #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IW'(k);
    end
  end
endmodule

// File: rtl/ics_source_ctl.sv
module ics_source_ctl
  import ics_pkg::*;
#(
  parameter int                 NUM_SRC    = 8,
  parameter int                 BASE       = 16,
  parameter int                 NUM_SRV    = 4,
  parameter int                 NUM_W      = 10,
  parameter int                 SRVIN_W    = 8,
  parameter int                 SRV_W      = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'('hF0)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               req_vld_i,
  input  logic [2:0]         req_op_i,
  input  logic [NUM_W-1:0]   req_num_i,
  input  logic [SRVIN_W-1:0] req_srv_i,
  input  logic [8:0]         req_pri_i,
  output logic               busy_o,
  output logic               ofr_vld_o,
  output logic [SRV_W-1:0]   ofr_srv_o,
  output logic [NUM_W-1:0]   ofr_num_o,
  output logic [7:0]         ofr_pri_o,
  output logic               rsp_vld_o,
  output logic               rsp_err_o,
  output logic [SRV_W-1:0]   rsp_srv_o,
  output logic [7:0]         rsp_pri_o
);
  localparam int                  LIDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [NUM_W-1:0]    NUM_LO  = NUM_W'(BASE);
  localparam logic [NUM_W-1:0]    NUM_HI  = NUM_W'(BASE + NUM_SRC);
  localparam logic [SRVIN_W-1:0]  SRV_LIM = SRVIN_W'(NUM_SRV);
  localparam logic [LIDX_W-1:0]   LAST    = LIDX_W'(NUM_SRC - 1);

  // Per-source entry and status
  logic [SRV_W-1:0]   srv_q  [NUM_SRC];
  logic [7:0]         pri_q  [NUM_SRC];
  logic [7:0]         spri_q [NUM_SRC];
  logic [NUM_SRC-1:0] sent_q, rej_q, mpend_q;

  logic              busy_q;
  logic [LIDX_W-1:0] scan_idx;

  // Raw input capture and arbitration
  logic [NUM_SRC-1:0] lvl, ev, ev_clr;
  logic               ev_any;
  logic [LIDX_W-1:0]  ev_idx;

  ics_edge_capture #(.N(NUM_SRC)) u_cap (
    .clk(clk), .rst(rst), .irq_i(irq_i), .clr_i(ev_clr), .lvl_o(lvl), .ev_o(ev)
  );

  ics_pick_low #(.N(NUM_SRC), .IW(LIDX_W)) u_pick (
    .req_i(ev), .any_o(ev_any), .idx_o(ev_idx)
  );

  // Request decode
  ics_op_e           op;
  logic              acc, num_ok, set_ok, cmd_ok, is_cmd;
  logic [LIDX_W-1:0] ridx;

  assign op     = ics_op_e'(req_op_i);
  assign acc    = req_vld_i && !busy_q;
  assign num_ok = (req_num_i >= NUM_LO) && (req_num_i < NUM_HI);
  assign ridx   = LIDX_W'(req_num_i - NUM_LO);
  assign set_ok = num_ok && (req_srv_i < SRV_LIM) && !req_pri_i[8];
  assign is_cmd = (op == OP_SET) || (op == OP_GET) || (op == OP_OFF) || (op == OP_ON);
  assign cmd_ok = (op == OP_SET) ? set_ok : num_ok;

  // Offer selection: walk first, then accepted request, then raw events
  logic              go;
  logic [LIDX_W-1:0] gidx;
  logic [SRV_W-1:0]  gsrv;
  logic [7:0]        gpri;

  always_comb begin
    go     = 1'b0;
    gidx   = ridx;
    gsrv   = srv_q[ridx];
    gpri   = pri_q[ridx];
    ev_clr = '0;
    if (busy_q) begin
      gidx = scan_idx;
      gsrv = srv_q[scan_idx];
      gpri = pri_q[scan_idx];
      if (LEVEL_MASK[scan_idx])
        go = (gpri != PRI_MASKED) && lvl[scan_idx] && !sent_q[scan_idx];
      else
        go = (gpri != PRI_MASKED) && rej_q[scan_idx];
    end else if (acc) begin
      if (op == OP_SET) begin
        gsrv = SRV_W'(req_srv_i);
        gpri = req_pri_i[7:0];
      end else if (op == OP_ON) begin
        gpri = spri_q[ridx];
      end
      if (((op == OP_SET) || (op == OP_ON)) && cmd_ok)
        go = (gpri != PRI_MASKED) &&
             (LEVEL_MASK[ridx] ? (lvl[ridx] && !sent_q[ridx]) : mpend_q[ridx]);
    end else if (ev_any) begin
      gidx           = ev_idx;
      gsrv           = srv_q[ev_idx];
      gpri           = pri_q[ev_idx];
      ev_clr[ev_idx] = 1'b1;
      go = (gpri != PRI_MASKED) && (!LEVEL_MASK[ev_idx] || (lvl[ev_idx] && !sent_q[ev_idx]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_SRC; k++) begin
        srv_q[k]  <= '0;
        pri_q[k]  <= PRI_MASKED;
        spri_q[k] <= PRI_MASKED;
      end
      sent_q    <= '0;
      rej_q     <= '0;
      mpend_q   <= '0;
      busy_q    <= 1'b0;
      scan_idx  <= '0;
      ofr_vld_o <= 1'b0;
      ofr_srv_o <= '0;
      ofr_num_o <= '0;
      ofr_pri_o <= '0;
      rsp_vld_o <= 1'b0;
      rsp_err_o <= 1'b0;
      rsp_srv_o <= '0;
      rsp_pri_o <= '0;
    end else begin
      ofr_vld_o <= go;
      ofr_srv_o <= gsrv;
      ofr_num_o <= NUM_LO + NUM_W'(gidx);
      ofr_pri_o <= gpri;
      rsp_vld_o <= acc && is_cmd;
      rsp_err_o <= acc && is_cmd && !cmd_ok;
      rsp_srv_o <= (acc && (op == OP_GET) && num_ok) ? srv_q[ridx] : '0;
      rsp_pri_o <= (acc && (op == OP_GET) && num_ok) ? pri_q[ridx] : 8'h00;

      if (go) begin
        if (LEVEL_MASK[gidx]) sent_q[gidx]  <= 1'b1;
        else                  mpend_q[gidx] <= 1'b0;
      end

      if (busy_q) begin
        if (!LEVEL_MASK[scan_idx]) rej_q[scan_idx] <= 1'b0;
        if (scan_idx == LAST) busy_q <= 1'b0;
        scan_idx <= scan_idx + 1'b1;
      end else if (acc) begin
        case (op)
          OP_REJECT: if (num_ok) begin
            rej_q[ridx]  <= 1'b1;
            sent_q[ridx] <= 1'b0;
          end
          OP_EOI: if (num_ok && LEVEL_MASK[ridx]) sent_q[ridx] <= 1'b0;
          OP_RESEND: begin
            busy_q   <= 1'b1;
            scan_idx <= '0;
          end
          OP_SET: if (set_ok) begin
            srv_q[ridx]  <= SRV_W'(req_srv_i);
            pri_q[ridx]  <= req_pri_i[7:0];
            spri_q[ridx] <= req_pri_i[7:0];
          end
          OP_OFF: if (num_ok) begin
            spri_q[ridx] <= pri_q[ridx];
            pri_q[ridx]  <= PRI_MASKED;
          end
          OP_ON: if (num_ok) pri_q[ridx] <= spri_q[ridx];
          default: ;
        endcase
      end else if (ev_any && !LEVEL_MASK[ev_idx] && (pri_q[ev_idx] == PRI_MASKED)) begin
        mpend_q[ev_idx] <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/ics_source_ctl_chk.sv
module ics_source_ctl_chk #(
  parameter int NUM_SRC = 8,
  parameter int BASE    = 16,
  parameter int NUM_SRV = 4,
  parameter int NUM_W   = 10,
  parameter int SRV_W   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_vld_i,
  input logic [2:0]       req_op_i,
  input logic             busy_o,
  input logic             ofr_vld_o,
  input logic [SRV_W-1:0] ofr_srv_o,
  input logic [NUM_W-1:0] ofr_num_o,
  input logic [7:0]       ofr_pri_o,
  input logic             rsp_vld_o
);
  logic [15:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) bcnt <= '0;
    else     bcnt <= busy_o ? bcnt + 16'd1 : 16'd0;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ofr_vld_o && !busy_o && !rsp_vld_o));

  a_r2_masked_never_offered: assert property (@(posedge clk) disable iff (rst)
    ofr_vld_o |-> (ofr_pri_o != 8'hFF));

  a_r2_offer_fields_legal: assert property (@(posedge clk) disable iff (rst)
    ofr_vld_o |-> ((int'(ofr_num_o) >= BASE) && (int'(ofr_num_o) < BASE + NUM_SRC)
                   && (int'(ofr_srv_o) < NUM_SRV)));

  a_r7_rsp_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    rsp_vld_o |-> $past(req_vld_i && !busy_o && (req_op_i >= 3'd3) && (req_op_i <= 3'd6)));

  a_r6_busy_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(req_vld_i && (req_op_i == 3'd2)));

  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (bcnt < 16'(NUM_SRC)));

  a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (bcnt == 16'(NUM_SRC)));
endmodule

bind ics_source_ctl ics_source_ctl_chk #(
  .NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_SRV(NUM_SRV), .NUM_W(NUM_W), .SRV_W(SRV_W)
) u_chk (
  .clk(clk), .rst(rst), .req_vld_i(req_vld_i), .req_op_i(req_op_i), .busy_o(busy_o),
  .ofr_vld_o(ofr_vld_o), .ofr_srv_o(ofr_srv_o), .ofr_num_o(ofr_num_o),
  .ofr_pri_o(ofr_pri_o), .rsp_vld_o(rsp_vld_o)
);

// File: tb/test_ics_source_ctl.sv
module test_ics_source_ctl;
  localparam int NS = 8;
  localparam int BS = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq = '0;
  logic       req_vld = 1'b0;
  logic [2:0] req_op = '0;
  logic [9:0] req_num = '0;
  logic [7:0] req_srv = '0;
  logic [8:0] req_pri = '0;
  logic       busy, ofr_vld, rsp_vld, rsp_err;
  logic [1:0] ofr_srv, rsp_srv;
  logic [9:0] ofr_num;
  logic [7:0] ofr_pri, rsp_pri;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ics_source_ctl #(
    .NUM_SRC(NS), .BASE(BS), .NUM_SRV(4), .NUM_W(10), .SRVIN_W(8), .LEVEL_MASK(8'hF0)
  ) i_ics_source_ctl (
    .clk(clk), .rst(rst), .irq_i(irq), .req_vld_i(req_vld), .req_op_i(req_op),
    .req_num_i(req_num), .req_srv_i(req_srv), .req_pri_i(req_pri), .busy_o(busy),
    .ofr_vld_o(ofr_vld), .ofr_srv_o(ofr_srv), .ofr_num_o(ofr_num), .ofr_pri_o(ofr_pri),
    .rsp_vld_o(rsp_vld), .rsp_err_o(rsp_err), .rsp_srv_o(rsp_srv), .rsp_pri_o(rsp_pri)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic req(int op, int num, int srv, int pri);
    req_vld = 1'b1; req_op = 3'(op); req_num = 10'(num);
    req_srv = 8'(srv); req_pri = 9'(pri);
    step();
    req_vld = 1'b0;
  endtask

  task automatic ofr(string tag, int v, int srv, int num, int pri);
    chk({tag, " offer valid"}, int'(ofr_vld), v);
    if (v != 0) begin
      chk({tag, " offer server"}, int'(ofr_srv), srv);
      chk({tag, " offer number"}, int'(ofr_num), num);
      chk({tag, " offer priority"}, int'(ofr_pri), pri);
    end
  endtask

  task automatic get(string tag, int idx, int srv, int pri);
    req(4, BS + idx, 0, 0);
    chk({tag, " get rsp"}, int'(rsp_vld), 1);
    chk({tag, " get err"}, int'(rsp_err), 0);
    chk({tag, " get server"}, int'(rsp_srv), srv);
    chk({tag, " get priority"}, int'(rsp_pri), pri);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1: quiet outputs and masked entries after reset
    chk("R1 busy", int'(busy), 0);
    chk("R1 offer", int'(ofr_vld), 0);
    chk("R1 rsp", int'(rsp_vld), 0);
    for (int i = 0; i < NS; i++) get("R1", i, 0, 255);

    // R7: parameter errors leave state untouched
    req(4, BS - 1, 0, 0);   chk("R7 low number err", int'(rsp_err), 1);
    req(4, BS + NS, 0, 0);  chk("R7 high number err", int'(rsp_err), 1);
    req(3, BS, 4, 8'h10);   chk("R7 server err", int'(rsp_err), 1);
    req(3, BS, 0, 256);     chk("R7 priority err", int'(rsp_err), 1);
    req(5, BS + NS, 0, 0);  chk("R7 off range err", int'(rsp_err), 1);
    get("R7 unchanged", 0, 0, 255);

    // R7: program every entry, no offers since nothing pending
    for (int i = 0; i < NS; i++) begin
      req(3, BS + i, i % 4, i * 16 + 1);
      chk("R7 set ok", int'(rsp_err), 0);
      ofr("R7 set no offer", 0, 0, 0, 0);
    end
    for (int i = 0; i < NS; i++) get("R7 readback", i, i % 4, i * 16 + 1);

    // R2: message sources
    for (int i = 0; i < 4; i++) begin
      irq[i] = 1'b1;
      step(); ofr("R2 first edge", 0, 0, 0, 0);
      step(); ofr("R2 offer", 1, i % 4, BS + i, i * 16 + 1);
      step(); ofr("R2 single", 0, 0, 0, 0);
      irq[i] = 1'b0;
    end

    // R4: level sources
    for (int i = 4; i < NS; i++) begin
      irq[i] = 1'b1;
      step(); step(); ofr("R4 first", 1, i % 4, BS + i, i * 16 + 1);
      irq[i] = 1'b0; step();
      irq[i] = 1'b1; step(); step(); ofr("R4 sent blocks", 0, 0, 0, 0);
      irq[i] = 1'b0; step();
      req(1, BS + i, 0, 0); ofr("R4 eoi no offer", 0, 0, 0, 0);
      irq[i] = 1'b1; step(); step(); ofr("R4 after eoi", 1, i % 4, BS + i, i * 16 + 1);
      if (i != 4) irq[i] = 1'b0;
      step();
    end

    // R3 / R8: masked message source, off then on
    req(5, BS + 1, 0, 0); chk("R8 off ok", int'(rsp_err), 0);
    get("R8 off masks", 1, 1, 255);
    irq[1] = 1'b1; step(); step(); ofr("R3 masked no offer", 0, 0, 0, 0);
    irq[1] = 1'b0;
    req(6, BS + 1, 0, 0); chk("R8 on ok", int'(rsp_err), 0);
    ofr("R3 pending delivered on", 1, 1, BS + 1, 8'h11);
    get("R8 on restores", 1, 1, 8'h11);
    req(5, BS + 2, 0, 0); req(5, BS + 2, 0, 0); req(6, BS + 2, 0, 0);
    get("R8 double off", 2, 2, 255);
    req(3, BS + 2, 2, 8'h21); ofr("R3 nothing pending", 0, 0, 0, 0);
    req(3, BS + 3, 3, 255);
    irq[3] = 1'b1; step(); step(); ofr("R3 masked by set", 0, 0, 0, 0);
    irq[3] = 1'b0;
    req(3, BS + 3, 3, 8'h31); ofr("R3 pending delivered set", 1, 3, BS + 3, 8'h31);

    // R5 / R6: reject then resend walk
    req(0, BS + 0, 0, 0); ofr("R5 reject no offer", 0, 0, 0, 0);
    req(0, BS + 4, 0, 0);
    req(1, BS + 1, 0, 0); ofr("R4 eoi on message", 0, 0, 0, 0);
    req(2, BS, 0, 0);
    chk("R6 busy rises", int'(busy), 1);
    ofr("R6 no offer at start", 0, 0, 0, 0);
    for (int s = 0; s < NS; s++) begin
      if (s == 0) begin
        req_vld = 1'b1; req_op = 3'd4; req_num = 10'(BS);
      end
      if (s == 2) irq[3] = 1'b1;
      step();
      req_vld = 1'b0;
      if (s == 0) begin
        ofr("R5 resend message", 1, 0, BS, 8'h01);
        chk("R6 request dropped", int'(rsp_vld), 0);
      end else if (s == 4) ofr("R5 resend level", 1, 0, BS + 4, 8'h41);
      else ofr("R6 walk quiet", 0, 0, 0, 0);
      chk("R6 busy length", int'(busy), (s < NS - 1) ? 1 : 0);
    end
    step(); ofr("R6 held edge", 1, 3, BS + 3, 8'h31);
    irq[3] = 1'b0;
    req(2, BS, 0, 0);
    for (int s = 0; s < NS; s++) begin
      step(); ofr("R5 rejected cleared", 0, 0, 0, 0);
    end

    // R9: arbitration among pending raw events
    irq[2:0] = 3'b111;
    step(); ofr("R9 latch", 0, 0, 0, 0);
    step(); ofr("R9 lowest first", 1, 0, BS, 8'h01);
    req(4, BS + 4, 0, 0);
    ofr("R9 request blocks raw", 0, 0, 0, 0);
    chk("R9 request answered", int'(rsp_vld), 1);
    step(); ofr("R9 second", 1, 1, BS + 1, 8'h11);
    step(); ofr("R9 third", 1, 2, BS + 2, 8'h21);
    step(); ofr("R9 drained", 0, 0, 0, 0);
    irq = '0;
    step();

    // R1: reset again, type survives
    rst = 1'b1; step(); step(); rst = 1'b0;
    chk("R1 busy after reset", int'(busy), 0);
    get("R1 cleared", 4, 0, 255);
    req(3, BS + 4, 0, 8'h41);
    irq[4] = 1'b1; step(); step(); ofr("R1 level kept", 1, 0, BS + 4, 8'h41);
    irq[4] = 1'b0; step();
    irq[4] = 1'b1; step(); step(); ofr("R1 level sent kept", 0, 0, 0, 0);
    irq[4] = 1'b0; step();

    finish_run();
  end
endmodule